// File: doc/BRIEF.md
# Synchronous Burst Read Address Sequencer

This block produces the word addresses a memory array must deliver during a pipelined synchronous burst read. A 16-bit configuration word picks the read mode, the initial wait before the first word, the spacing between later words, the wrap order, the burst length, the timing of a ready flag and the clock edge on which results are presented. A rising latch strobe captures the start address and the configuration. The sequencer then waits out the initial latency and walks through the burst, wrapping inside an aligned window or counting straight on in continuous mode.

The host paces the burst with an active-low advance input. When it is low at a due edge, the next word is presented; when it is high, the current word is held and stays valid. Dropping chip enable abandons the burst at once.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, beatAddr is 0 and beatValid and ready are low.
- R2: A burst starts at a clock edge where latchStrobe is high after being low the edge before, chipEn is high and cfgWord[15] is 0. The start address and the configuration are captured at that edge, called edge 0. The first word, at the start address, is valid in the cycle after edge X, whatever advanceN is.
- R3: The initial latency X is cfgWord[14:11] when that code lies in 2..12. Any other code gives X = 12.
- R4: cfgWord[9] sets the spacing between words: 0 gives one cycle and 1 gives two. With two-cycle spacing, beatValid is low in the cycle between words.
- R5: With cfgWord[7] = 0, words follow sequential order. The window of L words is aligned; word k sits at offset (s + k) mod L inside it, where s is the start offset.
- R6: With cfgWord[7] = 1, word k sits at offset s XOR k. For example, L = 8 and s = 5 give 5-4-7-6-1-0-3-2.
- R7: cfgWord[2:0] sets the length: 1 gives 2 words, 2 gives 4, 3 gives 8, and 7 gives continuous. The codes 0, 4, 5 and 6 give a single word. When wide32 is high, code 3 gives 4 words.
- R8: In continuous mode, word k is startAddr + k modulo 2^ADDR_W, with no wrap and no end.
- R9: After the first word, a due edge with advanceN high holds the current word. beatAddr stays the same and beatValid stays high until an edge with advanceN low moves on to the next word.
- R10: With cfgWord[8] = 0, ready equals beatValid. With cfgWord[8] = 1, ready is high exactly in the cycles before those in which beatValid will be high.
- R11: With cfgWord[6] = 1, beatAddr, beatValid and ready change on the falling clock edge, half a cycle after the rising-edge values they carry.
- R12: When cfgWord[15] is 1, a latch strobe starts no burst and beatValid stays low.
- R13: chipEn low at a rising edge ends any burst. beatValid and ready are then low, and no word follows until a new strobe.
- R14: A fixed-length burst ends at the first due edge after its last word, whatever advanceN is, and beatValid stays low afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWord | input | 16 | Read configuration, captured at burst start |
| wide32 | input | 1 | High selects the double-width organisation (length 8 not available) |
| chipEn | input | 1 | Chip enable, active high; low aborts |
| latchStrobe | input | 1 | Address latch strobe; a rising edge starts a burst |
| startAddr | input | ADDR_W | Start word address |
| advanceN | input | 1 | Active-low burst advance |
| beatAddr | output | ADDR_W | Address of the current word |
| beatValid | output | 1 | Current word valid |
| ready | output | 1 | Data-ready flag, same-cycle or one cycle early |

## Verification
The capture edge counts as edge 0, so the first word is due in the cycle after edge X. Later words follow Y edges apart, and a hold adds one edge each time. The bench builds an expected valid/address timeline per cycle from X, Y, the length, the order and its own advance pattern. It samples one nanosecond after each falling edge. At that point both rising-edge and falling-edge presentation have settled on the same value. The early ready flag is compared with the expected valid bit of the following cycle. The half-cycle lag of falling-edge mode is checked separately, with samples just after the rising edge.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int XLAT_W = 4;

  // Decoded burst configuration, held for the length of one burst
  typedef struct packed {
    logic                interleave;
    logic                continuous;
    logic [1:0]          lenLog2;
    logic                yTwo;
    logic                readyEarly;
    logic                fallEdge;
    logic [XLAT_W-1:0]   xLat;
  } burstCfg_t;

  // Strobes from the control to the address datapath
  typedef struct packed {
    logic load;
    logic present;
  } seqStrobe_t;
endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
#(
  parameter int XLAT_MAX = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [15:0] cfgWord,
  input  logic       wide32,
  input  logic       chipEn,
  input  logic       latchStrobe,
  input  logic       advanceN,
  output seqStrobe_t strobe,
  output burstCfg_t  cfgOut,
  output logic       validOut,
  output logic       readyOut,
  output logic       busy
);
  localparam logic [XLAT_W-1:0] X_TOP = XLAT_W'(XLAT_MAX);
  localparam logic [XLAT_W-1:0] X_MIN = XLAT_W'(2);

  function automatic burstCfg_t decodeCfg(input logic [15:0] w, input logic wide);
    burstCfg_t c;
    c.interleave = w[7];
    c.readyEarly = w[8];
    c.yTwo       = w[9];
    c.fallEdge   = w[6];
    c.xLat       = (w[14:11] < X_MIN || w[14:11] > X_TOP) ? X_TOP : w[14:11];
    c.continuous = (w[2:0] == 3'd7);
    case (w[2:0])
      3'd1:    c.lenLog2 = 2'd1;
      3'd2:    c.lenLog2 = 2'd2;
      3'd3:    c.lenLog2 = wide ? 2'd2 : 2'd3;
      default: c.lenLog2 = 2'd0;
    endcase
    return c;
  endfunction

  burstCfg_t newCfg, cfgQ;
  logic strobePrevQ, activeQ, firstDoneQ, validQ;
  logic [XLAT_W-1:0] waitQ;
  logic [3:0] leftQ;
  logic startReq, due, lastDone, endNow, present, holdNow;

  always_comb begin
    newCfg   = decodeCfg(cfgWord, wide32);
    startReq = latchStrobe & ~strobePrevQ & chipEn & ~cfgWord[15];
    due      = activeQ & (waitQ == '0);
    lastDone = firstDoneQ & (leftQ == '0) & ~cfgQ.continuous;
    endNow   = due & lastDone;
    present  = due & ~lastDone & (~firstDoneQ | ~advanceN);
    holdNow  = due & ~lastDone & ~present;
    strobe.load    = startReq;
    strobe.present = chipEn & ~startReq & present;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobePrevQ <= 1'b0;
      activeQ     <= 1'b0;
      firstDoneQ  <= 1'b0;
      validQ      <= 1'b0;
      waitQ       <= '0;
      leftQ       <= '0;
      cfgQ        <= '0;
    end else begin
      strobePrevQ <= latchStrobe;
      if (!chipEn) begin
        activeQ <= 1'b0;
        validQ  <= 1'b0;
      end else if (startReq) begin
        activeQ    <= 1'b1;
        validQ     <= 1'b0;
        firstDoneQ <= 1'b0;
        waitQ      <= newCfg.xLat - XLAT_W'(1);
        leftQ      <= 4'd1 << newCfg.lenLog2;
        cfgQ       <= newCfg;
      end else if (activeQ) begin
        if (endNow) begin
          activeQ <= 1'b0;
          validQ  <= 1'b0;
        end else if (present) begin
          validQ     <= 1'b1;
          firstDoneQ <= 1'b1;
          waitQ      <= {{(XLAT_W-1){1'b0}}, cfgQ.yTwo};
          leftQ      <= leftQ - 4'd1;
        end else if (holdNow) begin
          validQ <= 1'b1;
        end else begin
          validQ <= 1'b0;
          waitQ  <= waitQ - XLAT_W'(1);
        end
      end
    end
  end

  assign cfgOut   = cfgQ;
  assign validOut = validQ;
  assign busy     = activeQ;
  assign readyOut = chipEn & (cfgQ.readyEarly ? (due & ~lastDone) : validQ);
endmodule

// File: rtl/bseq_dpath.sv
module bseq_dpath
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  burstCfg_t         cfg,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              validIn,
  input  logic              readyIn,
  output logic [ADDR_W-1:0] posAddr,
  output logic [ADDR_W-1:0] beatAddr,
  output logic              beatValid,
  output logic              ready
);
  logic [ADDR_W-1:0] startQ, countQ, addrQ, mask, wrapPos, nextAddr;
  logic [ADDR_W-1:0] negAddrQ;
  logic negValidQ, negReadyQ;

  always_comb begin
    mask     = ~({ADDR_W{1'b1}} << cfg.lenLog2);
    wrapPos  = cfg.interleave ? (startQ ^ countQ) : (startQ + countQ);
    nextAddr = cfg.continuous ? (startQ + countQ)
                              : ((startQ & ~mask) | (wrapPos & mask));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startQ <= '0;
      countQ <= '0;
      addrQ  <= '0;
    end else if (strobe.load) begin
      startQ <= startAddr;
      countQ <= '0;
    end else if (strobe.present) begin
      addrQ  <= nextAddr;
      countQ <= countQ + ADDR_W'(1);
    end
  end

  // Half-cycle retiming stage for falling-edge presentation
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      negAddrQ  <= '0;
      negValidQ <= 1'b0;
      negReadyQ <= 1'b0;
    end else begin
      negAddrQ  <= addrQ;
      negValidQ <= validIn;
      negReadyQ <= readyIn;
    end
  end

  assign posAddr   = addrQ;
  assign beatAddr  = cfg.fallEdge ? negAddrQ  : addrQ;
  assign beatValid = cfg.fallEdge ? negValidQ : validIn;
  assign ready     = cfg.fallEdge ? negReadyQ : readyIn;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int ADDR_W   = 22,
  parameter int XLAT_MAX = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       cfgWord,
  input  logic              wide32,
  input  logic              chipEn,
  input  logic              latchStrobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              advanceN,
  output logic [ADDR_W-1:0] beatAddr,
  output logic              beatValid,
  output logic              ready
);
  seqStrobe_t        strobe;
  burstCfg_t         cfgCur;
  logic              ctlValid, ctlReady, ctlBusy;
  logic [ADDR_W-1:0] posAddr;

  bseq_ctrl #(.XLAT_MAX(XLAT_MAX)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .wide32(wide32),
    .chipEn(chipEn), .latchStrobe(latchStrobe), .advanceN(advanceN),
    .strobe(strobe), .cfgOut(cfgCur), .validOut(ctlValid),
    .readyOut(ctlReady), .busy(ctlBusy)
  );

  bseq_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfg(cfgCur),
    .startAddr(startAddr), .validIn(ctlValid), .readyIn(ctlReady),
    .posAddr(posAddr), .beatAddr(beatAddr), .beatValid(beatValid),
    .ready(ready)
  );
endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
  parameter int ADDR_W = 22
) (
  input logic              clk,
  input logic              rstN,
  input logic              chipEn,
  input logic              advanceN,
  input logic              latchStrobe,
  input logic              asyncSel,
  input logic              ctlValid,
  input logic              ctlActive,
  input logic [ADDR_W-1:0] posAddr
);
  // R13
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chipEn |=> (!ctlValid && !ctlActive));

  // R12
  async_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (latchStrobe && asyncSel && !ctlActive) |=> !ctlActive);

  // R9
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlValid && advanceN && chipEn && !latchStrobe) |=> (!ctlValid || $stable(posAddr)));

  // R14
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctlActive |-> !ctlValid);
endmodule

bind burst_addr_seq bseq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .chipEn(chipEn), .advanceN(advanceN),
  .latchStrobe(latchStrobe), .asyncSel(cfgWord[15]), .ctlValid(ctlValid),
  .ctlActive(ctlBusy), .posAddr(posAddr)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int AW = 22;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] cfgWord = '0;
  logic wide32 = 1'b0, chipEn = 1'b1, latchStrobe = 1'b0, advanceN = 1'b1;
  logic [AW-1:0] startAddr = '0;
  logic [AW-1:0] beatAddr;
  logic beatValid, ready;

  int checks = 0, errors = 0;
  bit finished = 0;
  bit expV[0:81];
  logic [AW-1:0] expA[0:81];

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u_burst_addr_seq (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .wide32(wide32),
    .chipEn(chipEn), .latchStrobe(latchStrobe), .startAddr(startAddr),
    .advanceN(advanceN), .beatAddr(beatAddr), .beatValid(beatValid),
    .ready(ready)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mkCfg(bit asy, int xc, bit y2, bit early,
                                        bit inter, bit fall, int lc);
    return {asy, 4'(xc), 1'b0, y2, early, inter, fall, 3'b000, 3'(lc)};
  endfunction

  function automatic int benchX(int code);
    return (code < 2 || code > 12) ? 12 : code;
  endfunction

  function automatic int benchLen(int code, bit wide);
    case (code)
      1: return 2;
      2: return 4;
      3: return wide ? 4 : 8;
      7: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic logic [AW-1:0] benchAddr(int start, int k, int len, bit inter);
    int base, s, pos;
    if (len == 0) return AW'(start + k);
    base = start - (start % len);
    s = start % len;
    pos = inter ? (s ^ k) : ((s + k) % len);
    return AW'(base + pos);
  endfunction

  task automatic runBurst(input string tag, input logic [15:0] cfg, input bit wide,
                          input int start, input int holdA, input int holdB);
    int xl = benchX(int'(cfg[14:11]));
    int yl = cfg[9] ? 2 : 1;
    int ln = benchLen(int'(cfg[2:0]), wide);
    bit early = cfg[8];
    int k = -1;
    int nextDue = xl;
    int beats = (ln == 0) ? 12 : ln;
    int nc = xl + beats * yl + 4 + ((holdA >= 0) ? 1 : 0) + ((holdB >= 0) ? 1 : 0);
    for (int c = 0; c <= 81; c++) begin
      expV[c] = 1'b0;
      expA[c] = (c > 0) ? expA[c-1] : '0;
      if (c > 0 && c == nextDue) begin
        if (k < 0) begin
          k = 0; expV[c] = 1'b1; expA[c] = benchAddr(start, 0, ln, cfg[7]); nextDue = c + yl;
        end else if (ln != 0 && k == ln - 1) begin
          nextDue = -1;
        end else if (c == holdA || c == holdB) begin
          expV[c] = 1'b1; nextDue = c + 1;
        end else begin
          k++; expV[c] = 1'b1; expA[c] = benchAddr(start, k, ln, cfg[7]); nextDue = c + yl;
        end
      end
    end
    @(negedge clk); #1;
    cfgWord = cfg; wide32 = wide; startAddr = AW'(start); latchStrobe = 1'b1; advanceN = 1'b0;
    for (int c = 0; c <= nc; c++) begin
      @(negedge clk); #1;
      latchStrobe = 1'b0;
      check(beatValid == expV[c], tag, "beatValid", beatValid, expV[c]);
      check(ready == (early ? expV[c+1] : expV[c]), "R10", "ready", ready,
            early ? expV[c+1] : expV[c]);
      if (expV[c]) check(beatAddr == expA[c], tag, "beatAddr", beatAddr, expA[c]);
      advanceN = (c + 1 == holdA || c + 1 == holdB);
    end
    advanceN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic fallCheck(input bit fall);
    @(negedge clk); #1;
    cfgWord = mkCfg(0, 2, 0, 0, 0, fall, 0); wide32 = 0;
    startAddr = AW'(22'h155); latchStrobe = 1'b1;
    @(posedge clk); #1 latchStrobe = 1'b0;
    @(posedge clk);
    @(posedge clk); #1;
    // R11: just after the due rising edge, falling-edge mode still shows the old value
    check(beatValid == !fall, "R11", "beatValid after rise", beatValid, !fall);
    @(negedge clk); #1;
    check(beatValid == 1'b1, "R11", "beatValid after fall", beatValid, 1);
    check(beatAddr == AW'(22'h155), "R11", "beatAddr", beatAddr, 22'h155);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int codes[6] = '{0, 1, 2, 3, 7, 5};
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    check(beatAddr == '0, "R1", "beatAddr", beatAddr, 0);
    check(beatValid == 1'b0, "R1", "beatValid", beatValid, 0);
    check(ready == 1'b0, "R1", "ready", ready, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    runBurst("R5", mkCfg(0, 8, 0, 0, 0, 0, 2), 0, 32'h1001, -1, -1);   // R2 R5 seq 4 from 1
    runBurst("R5", mkCfg(0, 3, 1, 0, 0, 0, 3), 0, 32'h2005, -1, -1);   // R4 seq 8 from 5
    runBurst("R6", mkCfg(0, 4, 0, 0, 1, 0, 2), 0, 32'h3001, -1, -1);   // R6 il 4 from 1
    runBurst("R6", mkCfg(0, 5, 0, 0, 1, 0, 3), 0, 32'h4005, -1, -1);   // R6 il 8 from 5
    runBurst("R8", mkCfg(0, 2, 0, 0, 0, 0, 7), 0, 32'h3FFFFA, -1, -1); // R8 continuous wraps top
    runBurst("R7", mkCfg(0, 3, 0, 0, 0, 0, 3), 1, 32'h0106, -1, -1);   // R7 wide32 length 8 -> 4
    runBurst("R7", mkCfg(0, 3, 0, 0, 1, 0, 6), 0, 32'h0107, -1, -1);   // R7 code 6 -> single
    runBurst("R3", mkCfg(0, 0, 0, 0, 0, 0, 1), 0, 32'h0011, -1, -1);   // R3 code 0 -> 12
    runBurst("R3", mkCfg(0, 15, 0, 0, 0, 0, 1), 0, 32'h0012, -1, -1);  // R3 code 15 -> 12
    runBurst("R9", mkCfg(0, 3, 0, 0, 0, 0, 2), 0, 32'h0012, 4, 5);     // R9 two holds
    runBurst("R9", mkCfg(0, 3, 1, 1, 1, 0, 3), 0, 32'h0023, 7, 8);     // R9 hold with Y=2, early R10
    runBurst("R10", mkCfg(0, 6, 1, 1, 0, 0, 2), 0, 32'h0031, -1, -1);  // R10 early ready
    runBurst("R14", mkCfg(0, 2, 0, 0, 0, 0, 1), 0, 32'h0041, -1, -1);  // R14 ends after last
    runBurst("R11", mkCfg(0, 4, 0, 1, 0, 1, 2), 0, 32'h0052, 5, -1);   // R11 falling stage
    fallCheck(1'b0);
    fallCheck(1'b1);

    // R12: asynchronous mode ignores the strobe
    @(negedge clk); #1;
    cfgWord = mkCfg(1, 2, 0, 1, 0, 0, 2); startAddr = AW'(22'h77); latchStrobe = 1'b1; advanceN = 1'b0;
    for (int c = 0; c < 16; c++) begin
      @(negedge clk); #1;
      latchStrobe = 1'b0;
      check(beatValid == 1'b0, "R12", "beatValid", beatValid, 0);
      check(ready == 1'b0, "R12", "ready", ready, 0);
    end

    // R13: chip enable low aborts a burst
    @(negedge clk); #1;
    cfgWord = mkCfg(0, 4, 0, 0, 0, 0, 3); startAddr = AW'(22'h80); latchStrobe = 1'b1;
    for (int c = 0; c <= 5; c++) begin
      @(negedge clk); #1;
      latchStrobe = 1'b0;
    end
    check(beatValid == 1'b1, "R13", "beatValid before abort", beatValid, 1);
    chipEn = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); #1;
      check(beatValid == 1'b0, "R13", "beatValid during abort", beatValid, 0);
      check(ready == 1'b0, "R13", "ready during abort", ready, 0);
    end
    chipEn = 1'b1;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk); #1;
      check(beatValid == 1'b0, "R13", "beatValid after abort", beatValid, 0);
    end
    advanceN = 1'b1;

    // Random bursts: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11
    for (int i = 0; i < 40; i++) begin
      int xc = int'($urandom % 16);
      int lc = codes[$urandom % 6];
      bit y2 = 1'($urandom);
      bit early = 1'($urandom);
      bit inter = 1'($urandom);
      bit fall = 1'($urandom);
      bit wide = 1'($urandom);
      int st = int'($urandom & 32'h3FFFFF);
      int xl = benchX(xc);
      int ha = ($urandom % 2) ? xl + 1 + int'($urandom % 3) : -1;
      runBurst("R2", mkCfg(0, xc, y2, early, inter, fall, lc), wide, st, ha, -1);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule